// File: doc/BRIEF.md
# Multidrop 9-bit Address Filter

This block sits behind a UART receiver on a shared multidrop bus of the RS-485 kind. Each received character holds nine bits. The low eight bits are the payload. The top bit is a flag that marks an address character, and it sits in the slot a parity bit would otherwise use. The filter decides, one character at a time, whether the character belongs to a frame addressed to this node. It forwards only the characters that do.

With 9-bit mode on, an address character is compared with a node address under a compare mask. A hit opens the frame, forwards the address character itself, and sets a sticky match status. A miss closes the frame. Data characters are forwarded only while a frame is open. Data that arrives after reset, before any hit, is therefore dropped, which removes junk received at start-up. With 9-bit mode off, the filter passes every good character straight through. A character with a framing error is never forwarded and leaves all state unchanged.

Top module: `mdrop_addr_filter`

## Requirements
- R1: After reset, outValid, outIsAddr, frameOpen, irqStatus and irq are all 0.
- R2: With nineBitEn=1, a character whose bit 8 is 1 is an address character. Its bits 7:0 are compared with nodeAddr on every bit position where addrMask holds a 1. A mask of 0xFF requires an exact match.
- R3: A matching address character is output one clock after it is accepted, with outValid=1, outData equal to the address and outIsAddr=1. The same edge sets frameOpen. While frameOpen=1, each data character (bit 8 = 0) is output one clock later with outIsAddr=0.
- R4: A non-matching address character is not output and clears frameOpen. Every data character after it is dropped until a matching address character arrives.
- R5: Data characters received after reset, before the first matching address, are dropped.
- R6: A matching address sets irqStatus on the same edge that raises frameOpen. irqStatus stays set until a cycle with irqClr=1. If a new match arrives in the same cycle as irqClr=1, irqStatus stays set.
- R7: irq equals irqStatus AND irqEn, with no added delay.
- R8: With nineBitEn=0, every good character is output one clock later with outData equal to bits 7:0 and outIsAddr=0. irqStatus is not set, and frameOpen is cleared.
- R9: A character with rxFrameErr=1 is never output. It does not change frameOpen or irqStatus.
- R10: Mask bits that are 0 are ignored in the compare, so addrMask=0x00 matches any address character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rxValid | input | 1 | A received character is present this cycle |
| rxChar | input | 9 | Received character: bit 8 is the address flag, bits 7:0 are the payload |
| rxFrameErr | input | 1 | Framing error on the present character |
| nineBitEn | input | 1 | Enables 9-bit address filtering |
| nodeAddr | input | 8 | Address of this node |
| addrMask | input | 8 | Compare mask; a 1 means the bit is compared |
| irqEn | input | 1 | Interrupt enable |
| irqClr | input | 1 | Clears the match status (write-1-to-clear strobe) |
| outValid | output | 1 | Forwarded character strobe |
| outData | output | 8 | Forwarded payload |
| outIsAddr | output | 1 | Forwarded character is the matching address |
| frameOpen | output | 1 | A matching frame is currently open |
| irqStatus | output | 1 | Sticky match status |
| irq | output | 1 | Gated match interrupt |

## Verification
A single stream of characters is driven through the filter. It contains data before any address, a near-miss address one bit off, an exact hit, a hit that carries a framing error, and a miss inside an open frame. Together these separate a filter that merely forwards everything from one that tracks frame state correctly. The same payloads are then sent with 9-bit mode off, and then with it on again, to show that pass-through mode also resets the frame state. Directed cases try partial and zero masks, the ordering between set and clear of the status, and the interrupt gate.

// File: rtl/mdrop_filter_pkg.sv
package mdrop_filter_pkg;
  // Strobes from control to datapath for one accepted character.
  typedef struct packed {
    logic fwd;     // forward this character
    logic isAddr;  // forwarded character is an address
    logic setIrq;  // raise the match status
  } ctrlStrobe_t;
endpackage

// File: rtl/mdrop_filter_ctrl.sv
module mdrop_filter_ctrl
  import mdrop_filter_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxValid,
  input  logic [DATA_W:0]   rxChar,
  input  logic              rxFrameErr,
  input  logic              nineBitEn,
  input  logic [DATA_W-1:0] nodeAddr,
  input  logic [DATA_W-1:0] addrMask,
  output ctrlStrobe_t       strobe,
  output logic              frameOpen
);
  localparam int FLAG_BIT = DATA_W;

  logic [DATA_W-1:0] bitOk;
  logic              addrHit;
  logic              goodChar;
  logic              isAddrChar;
  logic              frameNext;

  // Per-bit masked compare
  genvar gi;
  generate
    for (gi = 0; gi < DATA_W; gi++) begin : g_cmp
      assign bitOk[gi] = ~addrMask[gi] | (rxChar[gi] ~^ nodeAddr[gi]);
    end
  endgenerate

  assign addrHit    = &bitOk;
  assign goodChar   = rxValid & ~rxFrameErr;
  assign isAddrChar = rxChar[FLAG_BIT];

  always_comb begin
    strobe    = '0;
    frameNext = frameOpen;
    if (!nineBitEn) begin
      strobe.fwd = goodChar;
      frameNext  = 1'b0;
    end else if (goodChar && isAddrChar) begin
      strobe.fwd    = addrHit;
      strobe.isAddr = addrHit;
      strobe.setIrq = addrHit;
      frameNext     = addrHit;
    end else if (goodChar) begin
      strobe.fwd = frameOpen;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) frameOpen <= 1'b0;
    else       frameOpen <= frameNext;
  end
endmodule

// File: rtl/mdrop_filter_dp.sv
module mdrop_filter_dp
  import mdrop_filter_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W:0]   rxChar,
  input  ctrlStrobe_t       strobe,
  input  logic              irqEn,
  input  logic              irqClr,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              outIsAddr,
  output logic              irqStatus,
  output logic              irq
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      outData   <= '0;
      outIsAddr <= 1'b0;
    end else begin
      outValid  <= strobe.fwd;
      outIsAddr <= strobe.fwd & strobe.isAddr;
      if (strobe.fwd) outData <= rxChar[DATA_W-1:0];
    end
  end

  // Set has priority over the clear strobe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              irqStatus <= 1'b0;
    else if (strobe.setIrq) irqStatus <= 1'b1;
    else if (irqClr)        irqStatus <= 1'b0;
  end

  assign irq = irqStatus & irqEn;
endmodule

// File: rtl/mdrop_addr_filter.sv
module mdrop_addr_filter
  import mdrop_filter_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxValid,
  input  logic [DATA_W:0]   rxChar,
  input  logic              rxFrameErr,
  input  logic              nineBitEn,
  input  logic [DATA_W-1:0] nodeAddr,
  input  logic [DATA_W-1:0] addrMask,
  input  logic              irqEn,
  input  logic              irqClr,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              outIsAddr,
  output logic              frameOpen,
  output logic              irqStatus,
  output logic              irq
);
  ctrlStrobe_t strobe;

  mdrop_filter_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxChar(rxChar),
    .rxFrameErr(rxFrameErr), .nineBitEn(nineBitEn), .nodeAddr(nodeAddr),
    .addrMask(addrMask), .strobe(strobe), .frameOpen(frameOpen)
  );

  mdrop_filter_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .rxChar(rxChar), .strobe(strobe),
    .irqEn(irqEn), .irqClr(irqClr), .outValid(outValid), .outData(outData),
    .outIsAddr(outIsAddr), .irqStatus(irqStatus), .irq(irq)
  );
endmodule

// File: rtl/mdrop_addr_filter_chk.sv
module mdrop_addr_filter_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              rxValid,
  input logic [DATA_W:0]   rxChar,
  input logic              rxFrameErr,
  input logic              nineBitEn,
  input logic [DATA_W-1:0] nodeAddr,
  input logic [DATA_W-1:0] addrMask,
  input logic              irqEn,
  input logic              irqClr,
  input logic              outValid,
  input logic [DATA_W-1:0] outData,
  input logic              outIsAddr,
  input logic              frameOpen,
  input logic              irqStatus,
  input logic              irq
);
  logic addrMiss;
  assign addrMiss = ((rxChar[DATA_W-1:0] ^ nodeAddr) & addrMask) != '0;

  AST_OUT_NEEDS_INPUT: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(rxValid)); // R3

  AST_MISS_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !rxFrameErr && nineBitEn && rxChar[DATA_W] && addrMiss)
      |=> (!outValid && !frameOpen)); // R4

  AST_CLOSED_DATA_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !rxFrameErr && nineBitEn && !rxChar[DATA_W] && !frameOpen)
      |=> !outValid); // R5

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (irqStatus && !irqClr) |=> irqStatus); // R6

  AST_NO_STATUS_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (!nineBitEn && !irqStatus) |=> !irqStatus); // R8

  AST_ERR_NOT_FWD: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && rxFrameErr) |=> !outValid); // R9

  AST_ERR_KEEPS_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && rxFrameErr && nineBitEn) |=> $stable(frameOpen)); // R9
endmodule

bind mdrop_addr_filter mdrop_addr_filter_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_mdrop_addr_filter.sv
module tb_mdrop_addr_filter;
  localparam int CLK_PERIOD = 10;
  localparam int NROWS = 14;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxValid = 1'b0;
  logic [8:0] rxChar = '0;
  logic       rxFrameErr = 1'b0;
  logic       nineBitEn = 1'b1;
  logic [7:0] nodeAddr = 8'h5A;
  logic [7:0] addrMask = 8'hFF;
  logic       irqEn = 1'b0;
  logic       irqClr = 1'b0;
  logic       outValid, outIsAddr, frameOpen, irqStatus, irq;
  logic [7:0] outData;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdrop_addr_filter dut (.*);

  // Row: req[4] en err char[9] expV expD[8] expA expO
  typedef logic [25:0] row_t;
  localparam row_t TABLE [NROWS] = '{
    {4'd5, 1'b1, 1'b0, 9'h033, 1'b0, 8'h00, 1'b0, 1'b0}, // R5 junk data
    {4'd4, 1'b1, 1'b0, 9'h15B, 1'b0, 8'h00, 1'b0, 1'b0}, // R4 near miss
    {4'd4, 1'b1, 1'b0, 9'h011, 1'b0, 8'h00, 1'b0, 1'b0}, // R4 data dropped
    {4'd3, 1'b1, 1'b0, 9'h15A, 1'b1, 8'h5A, 1'b1, 1'b1}, // R3 hit, R2 exact
    {4'd3, 1'b1, 1'b0, 9'h0C3, 1'b1, 8'hC3, 1'b0, 1'b1}, // R3 data
    {4'd9, 1'b1, 1'b1, 9'h1A5, 1'b0, 8'h00, 1'b0, 1'b1}, // R9 bad addr keeps frame
    {4'd3, 1'b1, 1'b0, 9'h07E, 1'b1, 8'h7E, 1'b0, 1'b1}, // R3 data
    {4'd4, 1'b1, 1'b0, 9'h1A5, 1'b0, 8'h00, 1'b0, 1'b0}, // R4 miss closes
    {4'd4, 1'b1, 1'b0, 9'h044, 1'b0, 8'h00, 1'b0, 1'b0}, // R4
    {4'd8, 1'b0, 1'b0, 9'h1A5, 1'b1, 8'hA5, 1'b0, 1'b0}, // R8 pass through
    {4'd8, 1'b0, 1'b0, 9'h012, 1'b1, 8'h12, 1'b0, 1'b0}, // R8
    {4'd8, 1'b1, 1'b0, 9'h099, 1'b0, 8'h00, 1'b0, 1'b0}, // R8 frame cleared
    {4'd2, 1'b1, 1'b0, 9'h15A, 1'b1, 8'h5A, 1'b1, 1'b1}, // R2 hit again
    {4'd3, 1'b1, 1'b0, 9'h0FF, 1'b1, 8'hFF, 1'b0, 1'b1}  // R3
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Drive one character for one cycle, then sample after the edge
  task automatic sendChar(input logic en, input logic err, input logic [8:0] ch);
    nineBitEn  = en;
    rxFrameErr = err;
    rxChar     = ch;
    rxValid    = 1'b1;
    @(negedge clk);
    rxValid    = 1'b0;
    rxFrameErr = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "outValid", int'(outValid), 0);
    check("R1", "frameOpen", int'(frameOpen), 0);
    check("R1", "irqStatus", int'(irqStatus), 0);
    check("R1", "irq", int'(irq), 0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NROWS; i++) begin
      row_t r;
      string tag;
      r = TABLE[i];
      tag = $sformatf("R%0d row%0d", r[25:22], i);
      sendChar(r[21], r[20], r[19:11]);
      check(tag, "outValid", int'(outValid), int'(r[10]));
      if (r[10]) check(tag, "outData", int'(outData), int'(r[9:2]));
      check(tag, "outIsAddr", int'(outIsAddr), int'(r[1]));
      check(tag, "frameOpen", int'(frameOpen), int'(r[0]));
    end

    // R6 status set from hits; R7 gate
    check("R6", "irqStatus", int'(irqStatus), 1);
    check("R7", "irq gated off", int'(irq), 0);
    irqEn = 1'b1;
    #1;
    check("R7", "irq gated on", int'(irq), 1);
    // R6 clear
    irqClr = 1'b1;
    @(negedge clk);
    irqClr = 1'b0;
    check("R6", "cleared", int'(irqStatus), 0);
    check("R7", "irq after clear", int'(irq), 0);
    // R6 set wins over clear
    irqClr = 1'b1;
    sendChar(1'b1, 1'b0, 9'h15A);
    irqClr = 1'b0;
    check("R6", "set beats clear", int'(irqStatus), 1);
    irqClr = 1'b1;
    @(negedge clk);
    irqClr = 1'b0;
    // R8 no status in pass-through
    sendChar(1'b0, 1'b0, 9'h15A);
    check("R8", "no status", int'(irqStatus), 0);
    check("R8", "outIsAddr", int'(outIsAddr), 0);
    // R9 framing error on matching address: no open, no status
    sendChar(1'b1, 1'b1, 9'h15A);
    check("R9", "frameOpen", int'(frameOpen), 0);
    check("R9", "irqStatus", int'(irqStatus), 0);
    check("R9", "outValid", int'(outValid), 0);
    // R10 partial mask: only upper nibble compared
    addrMask = 8'hF0;
    sendChar(1'b1, 1'b0, 9'h153);
    check("R10", "partial hit valid", int'(outValid), 1);
    check("R10", "partial hit data", int'(outData), 8'h53);
    sendChar(1'b1, 1'b0, 9'h16A);
    check("R10", "partial miss", int'(outValid), 0);
    check("R10", "partial miss frame", int'(frameOpen), 0);
    // R10 zero mask matches anything
    addrMask = 8'h00;
    sendChar(1'b1, 1'b0, 9'h1C7);
    check("R10", "zero mask hit", int'(outIsAddr), 1);
    check("R10", "zero mask frame", int'(frameOpen), 1);
    // R2 exact mask: single differing bit misses
    addrMask = 8'hFF;
    sendChar(1'b1, 1'b0, 9'h1DA);
    check("R2", "bit7 differs", int'(outValid), 0);
    check("R2", "bit7 frame", int'(frameOpen), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule